// File: doc/BRIEF.md
# Performance Event Counter Bank with Overflow Interrupt

This block gives a processor core a small bank of event counters that software can program. Each counter is set up through a simple register interface. The setup picks one event line out of a vector of event strobes, such as a data cache miss, an instruction cache miss, a TLB miss, a mispredicted branch, a retired instruction or a line tied high for total cycles. Three enable bits, one for each privilege mode, decide in which execution modes the counter advances. Software can write a counter to any start value, which sets the distance to the next sample.

When a counter steps from all ones to zero, the block sets a sticky status bit for that counter and keeps counting. It raises the interrupt line if that counter's interrupt enable is set. The same edge stores the program counter that the core presents at that moment, so the handler can tag its sample. While any status bit is still set, the stored program counter does not change. A second overflow before service therefore cannot overwrite the first sample.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset every counter, every configuration word, the status word, the captured PC and `irq_o` are zero.
- R2: A counter advances by exactly one on each clock edge at which its selected event line (config bits [7:0] give the index into `evt_i`) is high and its mode filter allows counting. Event lines other than the selected one have no effect.
- R3: The mode filter uses `mode_i` encoded as 0 user, 1 kernel, 2 privileged library and 3 idle. Config bit 8 enables user, bit 9 kernel and bit 10 library. The counter holds when the current mode's enable bit is clear, and it never counts in mode 3.
- R4: A write to address i (0..3) loads counter i with `wdata_i[15:0]`. When the counter's event arrives in the same cycle, the write wins and no increment or overflow happens.
- R5: An increment from 0xFFFF wraps the counter to 0x0000 and sets status bit i at the same edge. Counting then continues from zero.
- R6: Writing to address 8 clears each status bit whose `wdata_i` bit is 1 and leaves the others alone. An overflow in the same cycle as the clear of its bit leaves that bit set.
- R7: `irq_o` is high exactly when some status bit is set whose counter has its interrupt enable (config bit 12) set.
- R8: On an edge where a counter wraps and no status bit is set, the captured PC takes the value of `pc_i`. While any status bit is set, the captured PC holds its value.
- R9: `rdata_o` shows counter i at address i, config word i at address 4+i, the status word at address 8 and the captured PC at address 9. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | One strobe per event class, sampled each edge |
| mode_i | input | 2 | Current privilege mode of the core |
| pc_i | input | 32 | Program counter of the core this cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for both write and read |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from state |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Every state change in the block lands at the clock edge that samples the cause. A counter value, a status bit or the captured PC therefore shows up one edge after the event strobe or write is presented. `irq_o` and `rdata_o` are combinational from that registered state and settle within the same cycle. The bench presents each stimulus at a falling edge and samples the outputs at the next falling edge, half a cycle after the rising edge that applied it. It reads back through the address port with writes idle. For each collision case the bench applies the write and the event in one cycle and checks the state after that single edge.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;

    // privilege mode encoding seen on mode_i
    typedef enum logic [1:0] {
        MODE_USER   = 2'd0,
        MODE_KERNEL = 2'd1,
        MODE_LIB    = 2'd2,
        MODE_IDLE   = 2'd3
    } priv_mode_e;

    // configuration word field positions
    localparam int CFG_SEL_LSB   = 0;
    localparam int CFG_USER_BIT  = 8;
    localparam int CFG_KERN_BIT  = 9;
    localparam int CFG_LIB_BIT   = 10;
    localparam int CFG_IRQ_BIT   = 12;

    // register address map
    localparam int ADDR_W        = 4;
    localparam int ADDR_CTR_BASE = 0;
    localparam int ADDR_CFG_BASE = 4;
    localparam int ADDR_STATUS   = 8;
    localparam int ADDR_PC       = 9;

endpackage

// File: rtl/evt_ctr_filter.sv
module evt_ctr_filter
    import evt_ctr_pkg::*;
#(
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [1:0]         mode_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               en_user_i,
    input  logic               en_kern_i,
    input  logic               en_lib_i,
    output logic               hit_o
);

    logic evt_seen;
    logic mode_ok;

    always_comb begin
        evt_seen = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (sel_i == SEL_W'(k)) begin
                evt_seen = evt_i[k];
            end
        end
        unique case (priv_mode_e'(mode_i))
            MODE_USER:   mode_ok = en_user_i;
            MODE_KERNEL: mode_ok = en_kern_i;
            MODE_LIB:    mode_ok = en_lib_i;
            default:     mode_ok = 1'b0;
        endcase
        hit_o = evt_seen & mode_ok;
    end

endmodule

// File: rtl/evt_ctr_slot.sv
module evt_ctr_slot
    import evt_ctr_pkg::*;
#(
    parameter int CTR_W   = 16,
    parameter int NUM_EVT = 8,
    parameter int SEL_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [1:0]        mode_i,
    input  logic              ctr_wr_i,
    input  logic              cfg_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CTR_W-1:0]  count_o,
    output logic [DATA_W-1:0] cfg_word_o,
    output logic              irq_en_o,
    output logic              wrap_o
);

    typedef struct packed {
        logic [CTR_W-1:0] count;
        logic [SEL_W-1:0] sel;
        logic             en_user;
        logic             en_kern;
        logic             en_lib;
        logic             irq_en;
    } slot_state_t;

    slot_state_t state_d, state_q;
    logic        hit;

    evt_ctr_filter #(
        .NUM_EVT (NUM_EVT),
        .SEL_W   (SEL_W)
    ) u_filter (
        .evt_i     (evt_i),
        .mode_i    (mode_i),
        .sel_i     (state_q.sel),
        .en_user_i (state_q.en_user),
        .en_kern_i (state_q.en_kern),
        .en_lib_i  (state_q.en_lib),
        .hit_o     (hit)
    );

    always_comb begin
        state_d = state_q;
        wrap_o  = 1'b0;
        if (ctr_wr_i) begin
            state_d.count = wdata_i[CTR_W-1:0];
        end else if (hit) begin
            state_d.count = state_q.count + CTR_W'(1);
            wrap_o        = (state_q.count == {CTR_W{1'b1}});
        end
        if (cfg_wr_i) begin
            state_d.sel     = wdata_i[CFG_SEL_LSB +: SEL_W];
            state_d.en_user = wdata_i[CFG_USER_BIT];
            state_d.en_kern = wdata_i[CFG_KERN_BIT];
            state_d.en_lib  = wdata_i[CFG_LIB_BIT];
            state_d.irq_en  = wdata_i[CFG_IRQ_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cfg_word_o                            = '0;
        cfg_word_o[CFG_SEL_LSB +: SEL_W]      = state_q.sel;
        cfg_word_o[CFG_USER_BIT]              = state_q.en_user;
        cfg_word_o[CFG_KERN_BIT]              = state_q.en_kern;
        cfg_word_o[CFG_LIB_BIT]               = state_q.en_lib;
        cfg_word_o[CFG_IRQ_BIT]               = state_q.irq_en;
    end

    assign count_o  = state_q.count;
    assign irq_en_o = state_q.irq_en;

endmodule

// File: rtl/evt_ctr_capture.sv
module evt_ctr_capture #(
    parameter int NUM_CTRS = 4,
    parameter int PC_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CTRS-1:0] wrap_i,
    input  logic                clr_wr_i,
    input  logic [NUM_CTRS-1:0] clr_mask_i,
    input  logic [NUM_CTRS-1:0] irq_en_i,
    input  logic [PC_W-1:0]     pc_i,
    output logic [NUM_CTRS-1:0] status_o,
    output logic [PC_W-1:0]     pc_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [NUM_CTRS-1:0] status;
        logic [PC_W-1:0]     pc;
    } cap_state_t;

    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clr_wr_i) begin
            cap_d.status = cap_q.status & ~clr_mask_i;
        end
        // a fresh overflow outranks a clear of the same bit
        cap_d.status = cap_d.status | wrap_i;
        // only the first unserviced overflow records its PC
        if ((|wrap_i) && (cap_q.status == '0)) begin
            cap_d.pc = pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign status_o = cap_q.status;
    assign pc_o     = cap_q.pc;
    assign irq_o    = |(cap_q.status & irq_en_i);

endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
    import evt_ctr_pkg::*;
#(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 16,
    parameter int NUM_EVT  = 8,
    parameter int PC_W     = 32,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [1:0]         mode_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);

    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic [NUM_CTRS-1:0][CTR_W-1:0]  ctr_val;
    logic [NUM_CTRS-1:0][DATA_W-1:0] cfg_val;
    logic [NUM_CTRS-1:0]             ctr_wr;
    logic [NUM_CTRS-1:0]             cfg_wr;
    logic [NUM_CTRS-1:0]             irq_en;
    logic [NUM_CTRS-1:0]             wrap;
    logic [NUM_CTRS-1:0]             status_q;
    logic [PC_W-1:0]                 pc_cap_q;
    logic                            status_wr;

    assign status_wr = wr_en_i && (addr_i == ADDR_W'(ADDR_STATUS));

    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_slot
        assign ctr_wr[g] = wr_en_i && (addr_i == ADDR_W'(ADDR_CTR_BASE + g));
        assign cfg_wr[g] = wr_en_i && (addr_i == ADDR_W'(ADDR_CFG_BASE + g));

        evt_ctr_slot #(
            .CTR_W   (CTR_W),
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W),
            .DATA_W  (DATA_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i),
            .mode_i     (mode_i),
            .ctr_wr_i   (ctr_wr[g]),
            .cfg_wr_i   (cfg_wr[g]),
            .wdata_i    (wdata_i),
            .count_o    (ctr_val[g]),
            .cfg_word_o (cfg_val[g]),
            .irq_en_o   (irq_en[g]),
            .wrap_o     (wrap[g])
        );
    end

    evt_ctr_capture #(
        .NUM_CTRS (NUM_CTRS),
        .PC_W     (PC_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap),
        .clr_wr_i   (status_wr),
        .clr_mask_i (wdata_i[NUM_CTRS-1:0]),
        .irq_en_i   (irq_en),
        .pc_i       (pc_i),
        .status_o   (status_q),
        .pc_o       (pc_cap_q),
        .irq_o      (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_CTRS; k++) begin
            if (addr_i == ADDR_W'(ADDR_CTR_BASE + k)) begin
                rdata_o = DATA_W'(ctr_val[k]);
            end
            if (addr_i == ADDR_W'(ADDR_CFG_BASE + k)) begin
                rdata_o = cfg_val[k];
            end
        end
        if (addr_i == ADDR_W'(ADDR_STATUS)) begin
            rdata_o = DATA_W'(status_q);
        end
        if (addr_i == ADDR_W'(ADDR_PC)) begin
            rdata_o = DATA_W'(pc_cap_q);
        end
    end

endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk #(
    parameter int NUM_CTRS = 4,
    parameter int CTR_W    = 16,
    parameter int PC_W     = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en_i,
    input logic [ADDR_W-1:0]               addr_i,
    input logic [DATA_W-1:0]               wdata_i,
    input logic [1:0]                      mode_i,
    input logic                            irq_o,
    input logic [NUM_CTRS-1:0][CTR_W-1:0]  ctr_val,
    input logic [NUM_CTRS-1:0]             status_q,
    input logic [PC_W-1:0]                 pc_cap_q
);

    // R7: an interrupt needs a pending status bit
    assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_q != '0));

    // R8: pending status freezes the captured PC
    assert_pc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> (pc_cap_q == $past(pc_cap_q)));

    for (genvar g = 0; g < NUM_CTRS; g++) begin : g_chk
        // R4: a counter write lands on the next edge
        assert_preload_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == ADDR_W'(g)) |=> (ctr_val[g] == $past(wdata_i[CTR_W-1:0])));

        // R3: idle mode never advances a counter
        assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == 2'd3 && !(wr_en_i && addr_i == ADDR_W'(g)))
            |=> (ctr_val[g] == $past(ctr_val[g])));

        // R5: a status bit only appears after the counter sat at all ones
        assert_status_needs_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!status_q[g] && ctr_val[g] != {CTR_W{1'b1}}) |=> !status_q[g]);
    end

endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(
    .NUM_CTRS (NUM_CTRS),
    .CTR_W    (CTR_W),
    .PC_W     (PC_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (evt_ctr_pkg::ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .mode_i   (mode_i),
    .irq_o    (irq_o),
    .ctr_val  (ctr_val),
    .status_q (status_q),
    .pc_cap_q (pc_cap_q)
);

// File: tb/evt_ctr_bank_test.sv
module evt_ctr_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic [1:0]  mode_i = '0;
    logic [31:0] pc_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    evt_ctr_bank uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .mode_i  (mode_i),
        .pc_i    (pc_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    // {event strobes, mode, expected counter 0 afterwards}
    // counter 0 watches event 2 in user and kernel modes only
    localparam logic [25:0] VEC [0:7] = '{
        {8'h04, 2'd0, 16'd1},
        {8'h04, 2'd1, 16'd2},
        {8'h04, 2'd2, 16'd2},
        {8'h04, 2'd3, 16'd2},
        {8'hFB, 2'd0, 16'd2},
        {8'hFF, 2'd1, 16'd3},
        {8'h00, 2'd0, 16'd3},
        {8'h04, 2'd0, 16'd4}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        addr_i = a;
        #1;
        check(tag, rdata_o, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] e, input logic [31:0] p);
        @(negedge clk);
        evt_i = e;
        pc_i  = p;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd("R1 ctr0", 4'd0, 32'h0);
        rd("R1 ctr3", 4'd3, 32'h0);
        rd("R1 cfg1", 4'd5, 32'h0);
        rd("R1 status", 4'd8, 32'h0);
        rd("R1 pc", 4'd9, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // R9: config readback, unmapped address
        wr(4'd4, 32'h0000_0302);
        rd("R9 cfg0", 4'd4, 32'h0000_0302);
        rd("R9 unmapped", 4'd15, 32'h0);

        // R2 / R3: table of event and mode patterns
        addr_i = 4'd0;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            evt_i  = VEC[v][25:18];
            mode_i = VEC[v][17:16];
            @(negedge clk);
            evt_i  = '0;
            rd($sformatf("R2/R3 vector %0d", v), 4'd0, {16'h0, VEC[v][15:0]});
        end
        mode_i = 2'd0;

        // R4: preload and write-over-event collision on counter 1 (event 0, user)
        wr(4'd5, 32'h0000_0100);
        wr(4'd1, 32'h0000_1234);
        rd("R4 preload", 4'd1, 32'h0000_1234);
        @(negedge clk);
        evt_i   = 8'h01;
        wr_en_i = 1'b1;
        addr_i  = 4'd1;
        wdata_i = 32'h0000_0050;
        @(negedge clk);
        wr_en_i = 1'b0;
        evt_i   = '0;
        rd("R4 write wins", 4'd1, 32'h0000_0050);
        pulse(8'h01, 32'h0);
        rd("R4 count after write", 4'd1, 32'h0000_0051);

        // R5 / R8 / R7: overflow on counter 0 with interrupt enabled
        wr(4'd4, 32'h0000_1302);
        wr(4'd0, 32'h0000_FFFE);
        pulse(8'h04, 32'h0000_1000);
        rd("R5 at all ones", 4'd0, 32'h0000_FFFF);
        rd("R5 no status yet", 4'd8, 32'h0);
        check("R7 no irq yet", {31'b0, irq_o}, 32'h0);
        pulse(8'h04, 32'h0000_2000);
        rd("R5 wrapped", 4'd0, 32'h0);
        rd("R5 status set", 4'd8, 32'h1);
        rd("R8 pc captured", 4'd9, 32'h0000_2000);
        check("R7 irq raised", {31'b0, irq_o}, 32'h1);
        pulse(8'h04, 32'h0000_2100);
        rd("R5 counts on", 4'd0, 32'h1);
        rd("R8 pc kept", 4'd9, 32'h0000_2000);

        // R8: second overflow (counter 1, irq off) keeps first sample
        wr(4'd1, 32'h0000_FFFF);
        pulse(8'h01, 32'h0000_3000);
        rd("R8 both pending", 4'd8, 32'h3);
        rd("R8 pc not replaced", 4'd9, 32'h0000_2000);

        // R6 / R7: write-one-to-clear
        wr(4'd8, 32'h1);
        rd("R6 clear bit0 only", 4'd8, 32'h2);
        check("R7 masked status no irq", {31'b0, irq_o}, 32'h0);
        rd("R8 pc held by bit1", 4'd9, 32'h0000_2000);
        wr(4'd8, 32'h2);
        rd("R6 all clear", 4'd8, 32'h0);

        // R8: new capture once idle
        wr(4'd0, 32'h0000_FFFF);
        pulse(8'h04, 32'h0000_4000);
        rd("R8 new capture", 4'd9, 32'h0000_4000);
        check("R7 irq again", {31'b0, irq_o}, 32'h1);

        // R6: clear of bits 0 and 1 while counter 1 wraps
        wr(4'd1, 32'h0000_FFFF);
        @(negedge clk);
        evt_i   = 8'h01;
        pc_i    = 32'h0000_5000;
        wr_en_i = 1'b1;
        addr_i  = 4'd8;
        wdata_i = 32'h3;
        @(negedge clk);
        wr_en_i = 1'b0;
        evt_i   = '0;
        rd("R6 set beats clear", 4'd8, 32'h2);
        rd("R8 pc while pending", 4'd9, 32'h0000_4000);
        check("R7 irq off bit0 cleared", {31'b0, irq_o}, 32'h0);

        // R3: library-mode enable only
        wr(4'd5, 32'h0000_0400);
        mode_i = 2'd2;
        pulse(8'h01, 32'h0);
        rd("R3 lib counts", 4'd1, 32'h1);
        mode_i = 2'd1;
        pulse(8'h01, 32'h0);
        rd("R3 kernel blocked", 4'd1, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule